// File: doc/BRIEF.md
# Flow-Through Burst SRAM Cycle Controller

This block models a synchronous static RAM with a common 32-bit data path split into four byte lanes. It is meant to sit behind a processor or cache controller bus. On each rising clock edge it samples the address, three chip selects, two address strobes, the advance input and the write controls. It then classifies the cycle as one of five kinds: idle, deselect, burst start, burst continue or burst suspend. A read returns its data in the cycle right after the edge that registered it, which is flow-through timing.

Two strobes can start a burst. The processor strobe always opens a read. The controller strobe can write on its very first clock. A two-bit wrapping counter walks the low address bits, in either linear or interleaved order. Data in and data out are separate ports. A `dout_en` signal stands in for the tri-state control of a shared bus. It is gated asynchronously by the active-low output enable, and it is forced low during writes, after a deselect, and on the first read clock that follows a deselected state.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at an edge where a strobe is recognised. A strobe edge that fails this test deselects the device. A deselect performs no write and leaves `dout_en` low in the following cycle.
- R2: `adsp_n`=0 with `ce1_n`=0 starts a read at `addr_in`. It ignores `gw_n`, `bwe_n` and `bw_n` on that clock, and it wins over a simultaneous `adsc_n`=0. When `ce1_n`=1, `adsp_n` is ignored.
- R3: `adsc_n`=0 without a recognised processor strobe starts a burst at `addr_in`. The burst writes on that same edge if a write is indicated, and reads otherwise.
- R4: A write is indicated when `gw_n`=0, or when `bwe_n`=0 and at least one bit of `bw_n` is 0. The case `bwe_n`=0 with `bw_n`=4'hF is a read.
- R5: `gw_n`=0 writes all four lanes. Otherwise `bw_n[0]` gates data bits 7:0, `bw_n[1]` gates bits 15:8, `bw_n[2]` gates bits 23:16 and `bw_n[3]` gates bits 31:24, each active low.
- R6: With no recognised strobe while a burst is active, `adv_n`=0 accesses the next burst address and `adv_n`=1 accesses the current address again. Each such cycle reads or writes according to R4.
- R7: The burst keeps the upper address bits of the start address. When `burst_mode`=0 the low two bits of the k-th access are (start+k) mod 4. When `burst_mode`=1 they are start XOR k.
- R8: Read data appears on `dout`, with `dout_en`=1 when enabled, in the cycle after the edge that registered the read.
- R9: `dout_en` is 0 during the cycle after a write edge whatever the value of `oe_n`. It is also 0 whenever `oe_n`=1, and it follows `oe_n` without waiting for a clock.
- R10: On the first read cycle of a burst started from the deselected state, `dout_en` stays 0 even with `oe_n`=0.
- R11: After a write, suspend reads keep `dout_en` at 0. The next strobe or advance read re-enables it.
- R12: After reset the device is deselected and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | AW | Word address sampled at a burst start |
| ce1_n | input | 1 | Chip select, active low; also qualifies the processor strobe |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte selects, active low |
| burst_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | LANES*LW | Write data |
| dout | output | LANES*LW | Read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
A controller-strobe burst is run that writes, suspends, advances and wraps. It is read back by a processor-strobe burst whose start carries an asserted global write; the later read-back shows whether the ignored write leaked through. An interleaved read starting at an odd address tells the XOR order apart from the linear one. Byte-select patterns, including the `bwe_n`=0/`bw_n`=4'hF corner, separate lane gating from the global write override. Deselecting strobes, a suspend read after a write, and toggling `oe_n` mid-cycle each isolate one of the output-disable conditions.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CY_IDLE  = 3'd0,
    CY_DESEL = 3'd1,
    CY_BEGIN = 3'd2,
    CY_CONT  = 3'd3,
    CY_SUSP  = 3'd4
  } cyc_kind_t;

  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       interleave);
    return interleave ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/bsram_addr_gen.sv
module bsram_addr_gen
  import bsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] start_lo,
  input  logic       interleave,
  output logic [1:0] cur_lo,
  output logic [1:0] nxt_lo
);
  logic [1:0] base_q;
  logic [1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= 2'd0;
      cnt_q  <= 2'd0;
    end else if (load) begin
      base_q <= start_lo;
      cnt_q  <= 2'd0;
    end else if (step) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  always_comb begin
    cur_lo = burst_lo(base_q, cnt_q, interleave);
    nxt_lo = burst_lo(base_q, cnt_q + 2'd1, interleave);
  end
endmodule

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_q,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output cyc_kind_t        kind,
  output logic             is_write,
  output logic [LANES-1:0] wr_lanes
);
  logic p_start;
  logic c_start;
  logic chip_ok;
  logic wr_req;
  logic [LANES-1:0] lane_req;

  always_comb begin
    p_start  = !adsp_n && !ce1_n;
    c_start  = !adsc_n && !p_start;
    chip_ok  = !ce1_n && ce2 && !ce3_n;
    lane_req = gw_n ? (~bw_n & {LANES{!bwe_n}}) : {LANES{1'b1}};
    wr_req   = |lane_req;

    kind     = CY_IDLE;
    is_write = 1'b0;
    if (p_start || c_start) begin
      kind     = chip_ok ? CY_BEGIN : CY_DESEL;
      is_write = c_start && chip_ok && wr_req;
    end else if (sel_q) begin
      kind     = adv_n ? CY_SUSP : CY_CONT;
      is_write = wr_req;
    end
    wr_lanes = is_write ? lane_req : '0;
  end
endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
  parameter int AW    = 5,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic [AW-1:0]       addr,
  input  logic                re,
  input  logic [LANES-1:0]    we,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LW +: LW];
      if (re)    rd_q      <= mem[addr];
    end

    assign rdata[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW    = 5,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr_in,
  input  logic                ce1_n,
  input  logic                ce2,
  input  logic                ce3_n,
  input  logic                adsp_n,
  input  logic                adsc_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [LANES-1:0]    bw_n,
  input  logic                burst_mode,
  input  logic                oe_n,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_en
);
  localparam int UPW = AW - 2;

  cyc_kind_t        kind;
  logic             is_write;
  logic [LANES-1:0] wr_lanes;
  logic             sel_q;
  logic             hold_z_q;
  logic             rd_q;
  logic             mask_q;
  logic [UPW-1:0]   upper_q;
  logic [1:0]       cur_lo;
  logic [1:0]       nxt_lo;
  logic [AW-1:0]    acc_addr;
  logic             access;
  logic             rd_en;

  bsram_decode #(.LANES(LANES)) u_dec (
    .sel_q(sel_q), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .kind(kind), .is_write(is_write), .wr_lanes(wr_lanes)
  );

  bsram_addr_gen u_agen (
    .clk(clk), .rst(rst),
    .load(kind == CY_BEGIN), .step(kind == CY_CONT),
    .start_lo(addr_in[1:0]), .interleave(burst_mode),
    .cur_lo(cur_lo), .nxt_lo(nxt_lo)
  );

  always_comb begin
    unique case (kind)
      CY_CONT: acc_addr = {upper_q, nxt_lo};
      CY_SUSP: acc_addr = {upper_q, cur_lo};
      default: acc_addr = addr_in;
    endcase
    access = (kind == CY_BEGIN) || (kind == CY_CONT) || (kind == CY_SUSP);
    rd_en  = access && !is_write;
  end

  bsram_lanes #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
    .clk(clk), .addr(acc_addr), .re(rd_en), .we(wr_lanes),
    .wdata(din), .rdata(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      hold_z_q <= 1'b0;
      rd_q     <= 1'b0;
      mask_q   <= 1'b0;
      upper_q  <= '0;
    end else begin
      if (kind == CY_BEGIN) begin
        sel_q   <= 1'b1;
        upper_q <= addr_in[AW-1:2];
      end else if (kind == CY_DESEL) begin
        sel_q   <= 1'b0;
      end

      if (is_write)
        hold_z_q <= 1'b1;
      else if (kind != CY_SUSP && kind != CY_IDLE)
        hold_z_q <= 1'b0;

      rd_q   <= rd_en && !(kind == CY_SUSP && hold_z_q);
      mask_q <= (kind == CY_BEGIN) && !is_write && !sel_q;
    end
  end

  assign dout_en = rd_q && !mask_q && !oe_n;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             adv_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bw_n,
  input logic             burst_mode,
  input logic             dout_en,
  input logic             sel_q,
  input logic             hold_z_q,
  input logic [1:0]       cur_lo
);
  logic strobe, chip_ok, wr_ind, p_ok;
  always_comb begin
    p_ok    = !adsp_n && !ce1_n;
    strobe  = p_ok || !adsc_n;
    chip_ok = !ce1_n && ce2 && !ce3_n;
    wr_ind  = !gw_n || (!bwe_n && !(&bw_n));
  end

  assert_write_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!p_ok && !adsc_n && chip_ok && wr_ind) |=> !dout_en);

  assert_desel_off_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe && !chip_ok) |=> !dout_en);

  assert_first_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && p_ok && chip_ok) |=> !dout_en);

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_q && !strobe && !adv_n && !burst_mode)
      |=> (burst_mode || cur_lo == $past(cur_lo) + 2'd1));

  assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_q && !strobe && adv_n)
      |=> (!$stable(burst_mode) || $stable(cur_lo)));

  assert_hold_z_R11: assert property (@(posedge clk) disable iff (rst)
    (hold_z_q && sel_q && !strobe && adv_n && !wr_ind) |=> !dout_en);
endmodule

bind burst_sram_ctrl burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
  .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .burst_mode(burst_mode),
  .dout_en(dout_en), .sel_q(sel_q), .hold_z_q(hold_z_q), .cur_lo(cur_lo)
);

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;
  localparam int AW = 5;
  localparam int LANES = 4;
  localparam int LW = 8;
  localparam int DW = LANES*LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [LANES-1:0] bw_n = '1;
  logic burst_mode = 1'b0;
  logic oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_sram_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) u_dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .burst_mode(burst_mode),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic no_wr();
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
  endtask

  // controller-strobe start
  task automatic c_start(logic [AW-1:0] a, logic gwn, logic bwen,
                         logic [3:0] bwn, logic [DW-1:0] d);
    addr_in = a; adsp_n = 1'b1; adsc_n = 1'b0; adv_n = 1'b1;
    gw_n = gwn; bwe_n = bwen; bw_n = bwn; din = d;
    step();
    adsc_n = 1'b1; no_wr();
  endtask

  // no strobe: advance (vn=0) or suspend (vn=1)
  task automatic beat(logic vn, logic gwn, logic [DW-1:0] d);
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = vn; gw_n = gwn; din = d;
    step();
    adv_n = 1'b1; no_wr();
  endtask

  task automatic t_reset();
    chk("R12 reset dout_en", {31'b0, dout_en}, 32'd0);
  endtask

  task automatic t_write_burst();
    c_start(5'd8, 1'b0, 1'b1, 4'hF, 32'h1111_0000);
    chk("R9 write start off with oe_n low", {31'b0, dout_en}, 32'd0);
    beat(1'b0, 1'b0, 32'h1111_0001);      // addr 9
    beat(1'b1, 1'b0, 32'h1111_0009);      // suspend write, addr 9 again
    beat(1'b0, 1'b0, 32'h1111_0002);      // addr 10
    beat(1'b0, 1'b0, 32'h1111_0003);      // addr 11
    beat(1'b0, 1'b0, 32'h1111_0004);      // wraps to addr 8
    chk("R9 continue write off", {31'b0, dout_en}, 32'd0);
    beat(1'b1, 1'b1, 32'hDEAD_BEEF);      // suspend read after write
    chk("R11 suspend read after write stays off", {31'b0, dout_en}, 32'd0);
    beat(1'b0, 1'b1, 32'hDEAD_BEEF);      // advance read -> addr 9
    chk("R11 advance read re-enables", {31'b0, dout_en}, 32'd1);
    chk("R6 suspend write replaced addr 9", dout, 32'h1111_0009);
  endtask

  task automatic t_proc_read();
    addr_in = 5'd3; ce1_n = 1'b1; adsc_n = 1'b0;
    step();
    adsc_n = 1'b1; ce1_n = 1'b0;
    chk("R1 deselect off", {31'b0, dout_en}, 32'd0);
    // processor + controller strobe together, with global write asserted
    addr_in = 5'd8; adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; din = 32'hBAD0_BAD0;
    step();
    adsp_n = 1'b1; adsc_n = 1'b1; no_wr();
    chk("R10 first read after deselect masked", {31'b0, dout_en}, 32'd0);
    beat(1'b1, 1'b1, '0);
    chk("R2 start ignored write, suspend reads addr 8", dout, 32'h1111_0004);
    chk("R8 flow-through enable", {31'b0, dout_en}, 32'd1);
    beat(1'b0, 1'b1, '0);
    chk("R7 linear addr 9", dout, 32'h1111_0009);
    beat(1'b0, 1'b1, '0);
    chk("R7 linear addr 10", dout, 32'h1111_0002);
    beat(1'b0, 1'b1, '0);
    chk("R7 linear addr 11", dout, 32'h1111_0003);
    beat(1'b0, 1'b1, '0);
    chk("R7 linear wrap addr 8", dout, 32'h1111_0004);
    // processor strobe with ce1_n high is ignored -> suspend at addr 8
    addr_in = 5'd20; ce1_n = 1'b1; adsp_n = 1'b0;
    step();
    ce1_n = 1'b0; adsp_n = 1'b1;
    chk("R2 ignored strobe keeps burst", dout, 32'h1111_0004);
    chk("R2 ignored strobe output on", {31'b0, dout_en}, 32'd1);
  endtask

  task automatic t_interleave();
    burst_mode = 1'b1;
    c_start(5'd9, 1'b1, 1'b1, 4'hF, '0);
    chk("R3 controller read start addr 9", dout, 32'h1111_0009);
    chk("R3 read start enabled", {31'b0, dout_en}, 32'd1);
    beat(1'b0, 1'b1, '0);
    chk("R7 interleaved 9^1", dout, 32'h1111_0004);
    beat(1'b0, 1'b1, '0);
    chk("R7 interleaved 9^2", dout, 32'h1111_0003);
    beat(1'b0, 1'b1, '0);
    chk("R7 interleaved 9^3", dout, 32'h1111_0002);
    burst_mode = 1'b0;
  endtask

  task automatic t_bytes();
    logic [DW-1:0] exp;
    c_start(5'd20, 1'b0, 1'b1, 4'hF, 32'hA1A2_A3A4);
    c_start(5'd20, 1'b1, 1'b0, 4'b1010, 32'h5566_7788);
    exp = 32'hA166_A388;
    c_start(5'd20, 1'b1, 1'b0, 4'hF, 32'hFFFF_FFFF);  // not a write
    chk("R4 bwe with no lanes is read", dout, exp);
    chk("R5 lanes 0 and 2 written", dout, exp);
    c_start(5'd20, 1'b1, 1'b1, 4'h0, 32'h0000_0000);  // bw without bwe: read
    chk("R4 lanes without bwe is read", dout, exp);
    c_start(5'd20, 1'b1, 1'b0, 4'b0111, 32'hC3C2_C1C0);
    c_start(5'd20, 1'b1, 1'b1, 4'hF, '0);
    chk("R5 lane 3 only", dout, 32'hC366_A388);
    c_start(5'd20, 1'b0, 1'b1, 4'hF, 32'h0BAD_F00D);
    c_start(5'd20, 1'b1, 1'b1, 4'hF, '0);
    chk("R5 global write overrides selects", dout, 32'h0BAD_F00D);
  endtask

  task automatic t_chip_sel();
    c_start(5'd21, 1'b0, 1'b1, 4'hF, 32'h2121_2121);
    ce3_n = 1'b1;
    c_start(5'd21, 1'b0, 1'b1, 4'hF, 32'hEEEE_EEEE);
    ce3_n = 1'b0;
    chk("R1 ce3_n high deselects", {31'b0, dout_en}, 32'd0);
    ce2 = 1'b0;
    c_start(5'd21, 1'b0, 1'b1, 4'hF, 32'hDDDD_DDDD);
    ce2 = 1'b1;
    chk("R1 ce2 low deselects", {31'b0, dout_en}, 32'd0);
    c_start(5'd21, 1'b1, 1'b1, 4'hF, '0);
    chk("R10 first read masked after deselect", {31'b0, dout_en}, 32'd0);
    beat(1'b1, 1'b1, '0);
    chk("R1 deselected writes dropped", dout, 32'h2121_2121);
    oe_n = 1'b1; #1;
    chk("R9 oe_n high turns off at once", {31'b0, dout_en}, 32'd0);
    oe_n = 1'b0; #1;
    chk("R9 oe_n low turns on at once", {31'b0, dout_en}, 32'd1);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_write_burst();
    t_proc_read();
    t_interleave();
    t_bytes();
    t_chip_sel();
    done = 1;
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      finish_up();
    end
  end
endmodule